// File: doc/BRIEF.md
# Frozen-Snapshot Real-Time Clock Register File

This block keeps a calendar clock in binary-coded decimal. It tracks seconds, minutes, hours (24-hour), day of week, date, month and a two-digit year, and advances them on each pulse of a one-second tick input. Software does not read the running counters directly. It reads a layer of holding registers, which normally follow the counters exactly. Setting a freeze bit in the control register pins the holding registers at the count present when the bit was written, so that a multi-byte read of the time cannot mix values from either side of a rollover. The counters keep running underneath, and clearing the bit brings every holding register up to date in one update.

The host reaches the block through a port shaped like an asynchronous SRAM. It has an active-low select, an active-low output enable, an active-low write enable, a 3-bit address, a write data bus, and a read data bus with a drive-enable flag for an external tristate buffer. Writes are taken on the rising clock edge. Read data is combinational. A power-good input that is low shuts the port off, while timekeeping continues.

Top module: `rtc_snapshot_regs`

## Requirements
- R1: A synchronous active-low reset clears the control register and sets the clock to 00:00:00, weekday 01, date 01, month 01, year 00. Every readable register shows these values after reset.
- R2: When `cs_n` is high or `pwr_ok` is low, `dq_oe` is 0 and `dq_out` is 0. When `cs_n=0`, `we_n=1`, `oe_n=0` and `pwr_ok=1`, `dq_oe` is 1 and `dq_out` carries the addressed register in the same cycle.
- R3: A write is taken at a rising edge with `cs_n=0`, `we_n=0` and `pwr_ok=1`, whatever the level of `oe_n`. During a write, `dq_oe` is 0.
- R4: Address map, all values in BCD: 0 is control, 1 seconds, 2 minutes, 3 hours, 4 weekday (1..7), 5 date, 6 month, 7 year. Control bit 6 is the freeze bit. The other control bits read as 0, and writes to them are ignored.
- R5: Each tick advances seconds. Seconds and minutes wrap from 59 to 00 and carry into the next field. Hours wrap from 23 to 00 and carry into the day fields. Without a tick or a time write, the counters hold.
- R6: A day carry wraps weekday 7 to 1. The date wraps after the month's last day: 30 for months 04, 06, 09 and 11; 28 for month 02, or 29 when the year is divisible by four; 31 for all other months. It then carries into the month. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R7: While the freeze bit is 0, the holding registers equal the counters after every clock edge, so a read in the cycle after a tick edge returns the new count.
- R8: Writing 1 to the freeze bit pins the holding registers at the counter values left by that write edge. They stay unchanged, whatever the ticks, for as long as the bit is 1.
- R9: The counters advance during a freeze. After the bit is written back to 0, all holding registers reload together at the next clock edge and show the advanced count.
- R10: A write to addresses 1..7 loads the written BCD value into that counter. A time write in the same cycle as a tick takes priority, and that tick is dropped. While frozen, a time write is not visible until the freeze is released.
- R11: While `pwr_ok` is 0, writes are ignored and nothing is driven, but ticks still advance the counters.
- R12: The freeze bit reads back at address 0, bit 6, from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| pwr_ok | input | 1 | Power good; low disables the host port |
| cs_n | input | 1 | Active-low select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | 3 | Register address |
| dq_in | input | 8 | Write data |
| dq_out | output | 8 | Read data, 0 when not driving |
| dq_oe | output | 1 | Drive enable for the external data buffer |

## Verification
Read data and `dq_oe` are combinational, so the bench checks them 5 ns after the falling edge on which the port inputs were driven. Writes and ticks act at the following rising edge, so their effects are looked for no earlier than the falling edge after that edge. A holding register that is not frozen follows in that same cycle. A released freeze shows up one clock edge after the clearing write, which means a read issued in the next cycle already returns the advanced count. A behavioural model updated on every rising edge predicts the bus each cycle, and scenario reads compare fixed BCD values at rollovers, leap February, the freeze, its release and power loss.

// File: rtl/rtc_snap_pkg.sv
// Package: shared widths, field indices, the time vector type and the
// BCD calendar helpers used by the counter chain.
// Assumes every stored field holds a valid two-digit BCD value.
package rtc_snap_pkg;

    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 3;
    localparam int NUM_FIELDS = 7;
    localparam int HALT_BIT   = 6;

    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DOW  = 3;
    localparam int F_DATE = 4;
    localparam int F_MON  = 5;
    localparam int F_YEAR = 6;

    typedef logic [NUM_FIELDS-1:0][DATA_W-1:0] rtc_time_t;

    // year 00, month 01, date 01, weekday 01, 00:00:00
    localparam rtc_time_t START_TIME =
        {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    // Next BCD value, wrapping from last back to first.
    function automatic logic [DATA_W-1:0] bcd_step(
        input logic [DATA_W-1:0] v,
        input logic [DATA_W-1:0] last,
        input logic [DATA_W-1:0] first);
        if (v == last)
            return first;
        else if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'h0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // True when a BCD year is divisible by four.
    function automatic logic bcd_leap(input logic [DATA_W-1:0] yr);
        if (yr[4] == 1'b0)
            return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
        else
            return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    endfunction

    // Last BCD date of a month.
    function automatic logic [DATA_W-1:0] month_last(
        input logic [DATA_W-1:0] mon,
        input logic [DATA_W-1:0] yr);
        case (mon)
            8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_counter_chain.sv
// Running calendar counters. They advance on the tick and can be loaded per
// field by the host. Exposes both the registered count and its next value.
// Assumes: tick is a single-cycle pulse; a time write drops a same-cycle tick.
module rtc_counter_chain
    import rtc_snap_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic [NUM_FIELDS-1:0] wr_sel,
    input  logic [DATA_W-1:0]     wr_data,
    output rtc_time_t             cnt_q,
    output rtc_time_t             cnt_d
);

    rtc_time_t         adv;
    logic [DATA_W-1:0] last_day;
    logic              c_sec, c_min, c_hour, c_day, c_mon, c_year;

    // Carry chain: each field steps when every lower field wraps.
    always_comb begin
        adv      = cnt_q;
        last_day = month_last(cnt_q[F_MON], cnt_q[F_YEAR]);
        c_sec    = tick && (wr_sel == '0);
        c_min    = c_sec  && (cnt_q[F_SEC]  == 8'h59);
        c_hour   = c_min  && (cnt_q[F_MIN]  == 8'h59);
        c_day    = c_hour && (cnt_q[F_HOUR] == 8'h23);
        c_mon    = c_day  && (cnt_q[F_DATE] == last_day);
        c_year   = c_mon  && (cnt_q[F_MON]  == 8'h12);
        if (c_sec)  adv[F_SEC]  = bcd_step(cnt_q[F_SEC],  8'h59, 8'h00);
        if (c_min)  adv[F_MIN]  = bcd_step(cnt_q[F_MIN],  8'h59, 8'h00);
        if (c_hour) adv[F_HOUR] = bcd_step(cnt_q[F_HOUR], 8'h23, 8'h00);
        if (c_day)  adv[F_DOW]  = bcd_step(cnt_q[F_DOW],  8'h07, 8'h01);
        if (c_day)  adv[F_DATE] = bcd_step(cnt_q[F_DATE], last_day, 8'h01);
        if (c_mon)  adv[F_MON]  = bcd_step(cnt_q[F_MON],  8'h12, 8'h01);
        if (c_year) adv[F_YEAR] = bcd_step(cnt_q[F_YEAR], 8'h99, 8'h00);
    end

    // Host load overrides the stepped value field by field.
    always_comb begin
        for (int i = 0; i < NUM_FIELDS; i++)
            cnt_d[i] = wr_sel[i] ? wr_data : adv[i];
    end

    // Counter storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= START_TIME;
        else
            cnt_q <= cnt_d;
    end

endmodule

// File: rtl/rtc_hold_regs.sv
// User-visible holding registers. Each one follows the counters' next value
// while the freeze flag is clear and keeps its value while it is set.
// Assumes freeze_q is the registered control bit, not its next value.
module rtc_hold_regs
    import rtc_snap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      freeze_q,
    input  rtc_time_t cnt_d,
    output rtc_time_t hold_q
);

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        // Reload this field unless frozen.
        always_ff @(posedge clk) begin
            if (!rst_n)
                hold_q[g] <= START_TIME[g];
            else if (!freeze_q)
                hold_q[g] <= cnt_d[g];
        end
    end

endmodule

// File: rtl/rtc_host_port.sv
// SRAM-style host port: access decode, the control register holding the
// freeze bit, and the read multiplexer.
// Assumes writes are sampled on the clock; reads are combinational.
module rtc_host_port
    import rtc_snap_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pwr_ok,
    input  logic                  cs_n,
    input  logic                  oe_n,
    input  logic                  we_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     dq_in,
    input  rtc_time_t             hold_q,
    output logic                  freeze_q,
    output logic [NUM_FIELDS-1:0] wr_sel,
    output logic [DATA_W-1:0]     dq_out,
    output logic                  dq_oe
);

    logic              selected, wr_en;
    logic [DATA_W-1:0] rd_data;

    assign selected = pwr_ok && !cs_n;
    assign wr_en    = selected && !we_n;
    assign dq_oe    = selected && we_n && !oe_n;

    // One select line per time field, at addresses 1..NUM_FIELDS.
    always_comb begin
        for (int i = 0; i < NUM_FIELDS; i++)
            wr_sel[i] = wr_en && (addr == ADDR_W'(i + 1));
    end

    // Control register: only the freeze bit is stored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            freeze_q <= 1'b0;
        else if (wr_en && addr == '0)
            freeze_q <= dq_in[HALT_BIT];
    end

    // Read multiplexer over control and holding registers.
    always_comb begin
        rd_data = '0;
        if (addr == '0)
            rd_data[HALT_BIT] = freeze_q;
        for (int i = 0; i < NUM_FIELDS; i++)
            if (addr == ADDR_W'(i + 1))
                rd_data = hold_q[i];
    end

    assign dq_out = dq_oe ? rd_data : '0;

endmodule

// File: rtl/rtc_snapshot_regs.sv
// Top: calendar counters, a freezable snapshot layer and the host port.
// Assumes sec_tick is synchronous to clk and one cycle wide.
module rtc_snapshot_regs
    import rtc_snap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              pwr_ok,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    rtc_time_t             cnt_q, cnt_d, hold_q;
    logic                  freeze_q;
    logic [NUM_FIELDS-1:0] wr_sel;

    rtc_host_port u_port (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .cs_n(cs_n),
        .oe_n(oe_n), .we_n(we_n), .addr(addr), .dq_in(dq_in),
        .hold_q(hold_q), .freeze_q(freeze_q), .wr_sel(wr_sel),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    rtc_counter_chain u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .wr_sel(wr_sel),
        .wr_data(dq_in), .cnt_q(cnt_q), .cnt_d(cnt_d)
    );

    rtc_hold_regs u_hold (
        .clk(clk), .rst_n(rst_n), .freeze_q(freeze_q),
        .cnt_d(cnt_d), .hold_q(hold_q)
    );

endmodule

// File: rtl/rtc_snapshot_chk.sv
// Checker: port and snapshot properties, bound into the top module.
module rtc_snapshot_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pwr_ok,
    input logic        cs_n,
    input logic        we_n,
    input logic        tick,
    input logic        time_wr,
    input logic        freeze_q,
    input logic [55:0] hold_q,
    input logic [55:0] cnt_q,
    input logic        dq_oe
);

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || !pwr_ok) |-> !dq_oe);                                   // R2
    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !dq_oe);                                               // R3
    AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !time_wr) |=> $stable(cnt_q));                         // R5
    AST_HOLD_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        !freeze_q |=> (hold_q == cnt_q));                                // R7
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_q |=> $stable(hold_q));                                   // R8
    AST_COUNT_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !time_wr) |=> !$stable(cnt_q));                         // R9
    AST_PWRFAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> $stable(freeze_q));                                  // R11

endmodule

bind rtc_snapshot_regs rtc_snapshot_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .cs_n(cs_n), .we_n(we_n),
    .tick(sec_tick), .time_wr(|wr_sel), .freeze_q(freeze_q),
    .hold_q(hold_q), .cnt_q(cnt_q), .dq_oe(dq_oe)
);

// File: tb/tb_rtc_snapshot_regs.sv
`timescale 1ns/1ps
module tb_rtc_snapshot_regs;

    logic       clk = 0, rst_n = 0, tick = 0, pwr_ok = 1;
    logic       cs_n = 1, oe_n = 1, we_n = 1;
    logic [2:0] addr = '0;
    logic [7:0] dq_in = '0;
    logic [7:0] dq_out;
    logic       dq_oe;

    int total = 0, bad = 0;
    bit chk_on = 0, done = 0;

    // Model: [0]sec [1]min [2]hour [3]weekday [4]date [5]month [6]year, binary.
    int m [7];
    int h [7];
    bit mhalt;

    rtc_snapshot_regs dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(tick), .pwr_ok(pwr_ok),
        .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] to_bcd(int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic int from_bcd(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int days_in(int mon, int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic model_advance();
        m[0]++;
        if (m[0] < 60) return;
        m[0] = 0; m[1]++;
        if (m[1] < 60) return;
        m[1] = 0; m[2]++;
        if (m[2] < 24) return;
        m[2] = 0;
        m[3] = (m[3] % 7) + 1;
        m[4]++;
        if (m[4] <= days_in(m[5], m[6])) return;
        m[4] = 1; m[5]++;
        if (m[5] <= 12) return;
        m[5] = 1;
        m[6] = (m[6] + 1) % 100;
    endtask

    // Reference model, stepped on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m = '{0, 0, 0, 1, 1, 1, 0};
            h = m;
            mhalt = 0;
        end else begin
            bit wr, old_halt;
            wr = pwr_ok && !cs_n && !we_n;
            old_halt = mhalt;
            if (wr && addr == 0) mhalt = dq_in[6];
            if (wr && addr != 0) m[addr - 1] = from_bcd(dq_in);
            else if (tick) model_advance();
            if (!old_halt) h = m;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [8:0] act,
                       input logic [8:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison of the bus against the model.
    always begin
        @(negedge clk);
        #5;
        if (chk_on) begin
            bit eoe;
            logic [7:0] ed;
            string tg;
            eoe = pwr_ok && !cs_n && we_n && !oe_n;
            ed  = !eoe ? 8'h00 : (addr == 0) ? (mhalt ? 8'h40 : 8'h00)
                                             : to_bcd(h[addr - 1]);
            tg  = !pwr_ok ? "R11" : (addr == 0) ? "R12" : mhalt ? "R8" : "R7";
            chk(dq_oe == eoe && dq_out == ed, tg, {dq_oe, dq_out}, {eoe, ed});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 0; we_n = 0; oe_n = 1; addr = a; dq_in = d;
        @(negedge clk);
        cs_n = 1; we_n = 1;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        cs_n = 0; we_n = 1; oe_n = 0; addr = a;
        #5;
        chk(dq_oe && dq_out == exp, tag, {dq_oe, dq_out}, {1'b1, exp});
        #1;
        cs_n = 1; oe_n = 1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1;
        end
        @(negedge clk);
        tick = 0;
    endtask

    task automatic set_eod(input logic [7:0] yr, input logic [7:0] mon,
                           input logic [7:0] date);
        wr(3'd7, yr); wr(3'd6, mon); wr(3'd5, date);
        wr(3'd3, 8'h23); wr(3'd2, 8'h59); wr(3'd1, 8'h59);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(20ns * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk_on = 1;
        // R1 reset state
        rd(3'd0, 8'h00, "R1"); rd(3'd1, 8'h00, "R1"); rd(3'd2, 8'h00, "R1");
        rd(3'd3, 8'h00, "R1"); rd(3'd4, 8'h01, "R1"); rd(3'd5, 8'h01, "R1");
        rd(3'd6, 8'h01, "R1"); rd(3'd7, 8'h00, "R1");
        // R5 seconds into minutes
        ticks(61);
        rd(3'd1, 8'h01, "R5"); rd(3'd2, 8'h01, "R5");
        // R10 load time, R5/R6 end of non-leap February
        wr(3'd4, 8'h07);
        wr(3'd7, 8'h03); wr(3'd6, 8'h02); wr(3'd5, 8'h28);
        wr(3'd3, 8'h23); wr(3'd2, 8'h59); wr(3'd1, 8'h58);
        rd(3'd3, 8'h23, "R10"); rd(3'd1, 8'h58, "R10");
        ticks(2);
        rd(3'd1, 8'h00, "R5"); rd(3'd2, 8'h00, "R5"); rd(3'd3, 8'h00, "R5");
        rd(3'd4, 8'h01, "R6"); rd(3'd5, 8'h01, "R6"); rd(3'd6, 8'h03, "R6");
        // R6 leap year February
        set_eod(8'h04, 8'h02, 8'h28);
        ticks(1);
        rd(3'd5, 8'h29, "R6"); rd(3'd6, 8'h02, "R6");
        set_eod(8'h04, 8'h02, 8'h29);
        ticks(1);
        rd(3'd5, 8'h01, "R6"); rd(3'd6, 8'h03, "R6");
        // R6 thirty-day month
        set_eod(8'h04, 8'h04, 8'h30);
        ticks(1);
        rd(3'd5, 8'h01, "R6"); rd(3'd6, 8'h05, "R6");
        // R6 year wrap
        set_eod(8'h99, 8'h12, 8'h31);
        ticks(1);
        rd(3'd7, 8'h00, "R6"); rd(3'd6, 8'h01, "R6"); rd(3'd5, 8'h01, "R6");
        // R12/R8 freeze
        wr(3'd0, 8'h40);
        rd(3'd0, 8'h40, "R12");
        ticks(5);
        rd(3'd1, 8'h00, "R8");
        wr(3'd0, 8'hFF);
        rd(3'd0, 8'h40, "R4");
        // R9 release shows advanced count
        wr(3'd0, 8'h00);
        rd(3'd1, 8'h05, "R9");
        rd(3'd0, 8'h00, "R9");
        // R10 write while frozen
        wr(3'd0, 8'h40);
        wr(3'd1, 8'h30);
        rd(3'd1, 8'h05, "R10");
        wr(3'd0, 8'h00);
        rd(3'd1, 8'h30, "R10");
        // R10 time write beats a same-cycle tick
        @(negedge clk);
        tick = 1; cs_n = 0; we_n = 0; addr = 3'd2; dq_in = 8'h10;
        @(negedge clk);
        tick = 0; cs_n = 1; we_n = 1;
        rd(3'd1, 8'h30, "R10"); rd(3'd2, 8'h10, "R10");
        // R11 power loss: no write, no drive, counting continues
        pwr_ok = 0;
        wr(3'd0, 8'h40);
        @(negedge clk);
        cs_n = 0; oe_n = 0; we_n = 1; addr = 3'd1;
        #5;
        chk(!dq_oe && dq_out == 8'h00, "R11", {dq_oe, dq_out}, 9'h000);
        #1;
        cs_n = 1; oe_n = 1;
        ticks(3);
        pwr_ok = 1;
        rd(3'd0, 8'h00, "R11"); rd(3'd1, 8'h33, "R11");
        // R3 write with output enable also low
        @(negedge clk);
        cs_n = 0; we_n = 0; oe_n = 0; addr = 3'd2; dq_in = 8'h45;
        #5;
        chk(!dq_oe, "R3", {dq_oe, dq_out}, 9'h000);
        @(negedge clk);
        cs_n = 1; we_n = 1; oe_n = 1;
        rd(3'd2, 8'h45, "R3");
        // R2 deselected with output enable low
        @(negedge clk);
        cs_n = 1; oe_n = 0; addr = 3'd1;
        #5;
        chk(!dq_oe && dq_out == 8'h00, "R2", {dq_oe, dq_out}, 9'h000);
        #1;
        oe_n = 1;
        repeat (2) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule